// File: doc/BRIEF.md
# Write-Once Snoopy Coherence Controller

This block keeps the coherence state of a small direct-mapped cache that sits on a shared snooping bus. Every line is in one of four states: invalid, valid-shared, reserved, or dirty. Reserved means this cache holds the only copy and it matches memory. Dirty means this cache holds the only copy and memory is stale. The block accepts one local access per cycle (a read or a write from the owning processor) and one snooped bus access per cycle (a read or a write seen from another agent). For each accepted access it reports, one cycle later, the outcome and the bus traffic the access needs.

For a local access it reports whether the access hit, the line's new state, and the bus operation to issue: none, a line read, or a write-through. If the line being replaced is dirty, it also asks for a write-back of that line. For a snooped access it reports whether the snoop hit a valid copy, and whether this cache must supply the data because it holds the only up-to-date copy.

The protocol's defining rule is the treatment of the first write to a shared line. That write goes through to memory and claims the line as reserved. Later writes stay local and mark the line dirty, so they need no bus traffic until the line is written back.

Top module: `wo_coh_ctrl`

## Requirements
- R1: After reset every line is invalid (state code 0), so the first local read of any address misses.
- R2: A local read miss issues a bus read (bus op code 1) on the request address, reports hit 0, and leaves the line valid-shared (state code 1).
- R3: A local read hit issues no bus operation (code 0), reports hit 1, and reports the line's state unchanged.
- R4: A local write to a valid-shared line issues a write-through (bus op code 2) on the request address and moves the line to reserved (state code 2).
- R5: A local write to a reserved line moves it to dirty (state code 3), and a local write to a dirty line keeps it dirty; neither issues a bus operation.
- R6: A local write miss issues a write-through on the request address and allocates the line as reserved with the new tag.
- R7: A miss that replaces a dirty line raises the eviction write-back flag with the old line's address, formed as {old tag, index}. Replacing a reserved or valid-shared line raises no such flag.
- R8: A snooped read that hits a dirty line raises the supply flag and moves the line to valid-shared.
- R9: A snooped read that hits a reserved line moves it to valid-shared without raising the supply flag. On a valid-shared line it changes nothing.
- R10: A snooped write that hits any valid line invalidates it. A snoop whose tag differs from the stored tag reports no hit and has no effect on the line.
- R11: When a snoop and a local access reach the same index in one cycle, the snoop is applied first and the local access acts on the post-snoop state.
- R12: All outputs are registered. A response appears exactly one cycle after its request, and the response valid, supply, snoop hit, eviction and bus op outputs are idle in cycles that follow no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_valid | input | 1 | Local access present |
| lcl_write | input | 1 | Local access is a write |
| lcl_addr | input | ADDR_W | Local access line address |
| snp_valid | input | 1 | Snooped bus access present |
| snp_write | input | 1 | Snooped access is a write |
| snp_addr | input | ADDR_W | Snooped access line address |
| rsp_valid | output | 1 | Local response present |
| rsp_hit | output | 1 | Local access hit a valid line |
| rsp_state | output | 2 | New line state (0 I, 1 V, 2 R, 3 D) |
| bus_op | output | 2 | Bus operation (0 none, 1 read, 2 write-through) |
| bus_addr | output | ADDR_W | Address of the bus operation |
| evict_wb | output | 1 | Write back the replaced dirty line |
| evict_addr | output | ADDR_W | Address of the replaced line |
| snp_hit | output | 1 | Snoop matched a valid line |
| snp_supply | output | 1 | This cache must supply the snooped data |

## Verification
The bench builds the controller with a 10-bit address and a 2-bit index, so there are four lines and 8-bit tags. With only four lines, two addresses that differ only in tag share one index. That makes replacement of dirty, reserved and shared lines easy to provoke. It also allows snoops whose tags match or miss to be aimed at a chosen line. Same-cycle collisions of a snoop and a local access on one index are driven directly, to exercise the snoop-first ordering.

// File: rtl/wo_pkg.sv
package wo_pkg;

  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_V = 2'd1,
    LN_R = 2'd2,
    LN_D = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BOP_NONE  = 2'd0,
    BOP_READ  = 2'd1,
    BOP_WTHRU = 2'd2
  } bus_op_e;

  // state after a snoop that hit a valid line
  function automatic line_st_e snoop_next(input line_st_e st, input logic is_wr);
    if (is_wr)          return LN_I;
    else if (st == LN_I) return LN_I;
    else                return LN_V;
  endfunction

  // state after a local access
  function automatic line_st_e local_next(input line_st_e st, input logic hit,
                                          input logic is_wr);
    if (!hit)       return is_wr ? LN_R : LN_V;
    else if (!is_wr) return st;
    else if (st == LN_V) return LN_R;
    else            return LN_D;
  endfunction

  // bus operation for a local access
  function automatic bus_op_e local_bus(input line_st_e st, input logic hit,
                                        input logic is_wr);
    if (!hit)             return is_wr ? BOP_WTHRU : BOP_READ;
    else if (is_wr && st == LN_V) return BOP_WTHRU;
    else                  return BOP_NONE;
  endfunction

endpackage

// File: rtl/wo_tag_array.sv
module wo_tag_array
  import wo_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output line_st_e         ra_st,
  output logic [TAG_W-1:0] ra_tag,
  input  logic [IDX_W-1:0] rb_idx,
  output line_st_e         rb_st,
  output logic [TAG_W-1:0] rb_tag,
  input  logic             wl_en,
  input  logic [IDX_W-1:0] wl_idx,
  input  line_st_e         wl_st,
  input  logic [TAG_W-1:0] wl_tag,
  input  logic             ws_en,
  input  logic [IDX_W-1:0] ws_idx,
  input  line_st_e         ws_st
);

  line_st_e         st_q  [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (!rst_n) begin
        st_q[e]  <= LN_I;
        tag_q[e] <= '0;
      end else if (wl_en && wl_idx == IDX_W'(e)) begin
        st_q[e]  <= wl_st;
        tag_q[e] <= wl_tag;
      end else if (ws_en && ws_idx == IDX_W'(e)) begin
        st_q[e]  <= ws_st;
      end
    end
  end

  assign ra_st  = st_q[ra_idx];
  assign ra_tag = tag_q[ra_idx];
  assign rb_st  = st_q[rb_idx];
  assign rb_tag = tag_q[rb_idx];

endmodule

// File: rtl/wo_snoop_unit.sv
module wo_snoop_unit
  import wo_pkg::*;
#(
  parameter int TAG_W = 9
) (
  input  logic             snp_valid,
  input  logic             snp_write,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_st_e         cur_st,
  input  logic [TAG_W-1:0] cur_tag,
  output logic             hit,
  output logic             supply,
  output line_st_e         nxt_st
);

  assign hit    = snp_valid && (cur_st != LN_I) && (cur_tag == snp_tag);
  assign supply = hit && !snp_write && (cur_st == LN_D);
  assign nxt_st = hit ? snoop_next(cur_st, snp_write) : cur_st;

endmodule

// File: rtl/wo_local_unit.sv
module wo_local_unit
  import wo_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9,
  localparam int ADDR_W = IDX_W + TAG_W
) (
  input  logic              lcl_valid,
  input  logic              lcl_write,
  input  logic [TAG_W-1:0]  lcl_tag,
  input  logic [IDX_W-1:0]  lcl_idx,
  input  line_st_e          cur_st,
  input  logic [TAG_W-1:0]  cur_tag,
  output logic              hit,
  output line_st_e          nxt_st,
  output bus_op_e           op,
  output logic              evict,
  output logic [ADDR_W-1:0] victim_addr
);

  assign hit         = (cur_st != LN_I) && (cur_tag == lcl_tag);
  assign nxt_st      = local_next(cur_st, hit, lcl_write);
  assign op          = lcl_valid ? local_bus(cur_st, hit, lcl_write) : BOP_NONE;
  assign evict       = lcl_valid && !hit && (cur_st == LN_D);
  assign victim_addr = {cur_tag, lcl_idx};

endmodule

// File: rtl/wo_coh_ctrl.sv
module wo_coh_ctrl
  import wo_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcl_valid,
  input  logic              lcl_write,
  input  logic [ADDR_W-1:0] lcl_addr,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_state,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              evict_wb,
  output logic [ADDR_W-1:0] evict_addr,
  output logic              snp_hit,
  output logic              snp_supply
);

  logic [IDX_W-1:0] l_idx, s_idx;
  logic [TAG_W-1:0] l_tag, s_tag;
  assign l_idx = lcl_addr[IDX_W-1:0];
  assign l_tag = lcl_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  line_st_e         arr_l_st, arr_s_st;
  logic [TAG_W-1:0] arr_l_tag, arr_s_tag;

  // named internal events
  logic             ev_snp_hit, ev_snp_supply, ev_same_idx;
  line_st_e         snp_nxt, lcl_view_st, lcl_nxt;
  logic             ev_lcl_hit, ev_evict;
  bus_op_e          lcl_op;
  logic [ADDR_W-1:0] victim;

  wo_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_write (snp_write),
    .snp_tag   (s_tag),
    .cur_st    (arr_s_st),
    .cur_tag   (arr_s_tag),
    .hit       (ev_snp_hit),
    .supply    (ev_snp_supply),
    .nxt_st    (snp_nxt)
  );

  // snoop is ordered ahead of a local access on the same index
  assign ev_same_idx = snp_valid && lcl_valid && (s_idx == l_idx);
  assign lcl_view_st = ev_same_idx ? snp_nxt : arr_l_st;

  wo_local_unit #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_local (
    .lcl_valid   (lcl_valid),
    .lcl_write   (lcl_write),
    .lcl_tag     (l_tag),
    .lcl_idx     (l_idx),
    .cur_st      (lcl_view_st),
    .cur_tag     (arr_l_tag),
    .hit         (ev_lcl_hit),
    .nxt_st      (lcl_nxt),
    .op          (lcl_op),
    .evict       (ev_evict),
    .victim_addr (victim)
  );

  wo_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_idx (l_idx),
    .ra_st  (arr_l_st),
    .ra_tag (arr_l_tag),
    .rb_idx (s_idx),
    .rb_st  (arr_s_st),
    .rb_tag (arr_s_tag),
    .wl_en  (lcl_valid),
    .wl_idx (l_idx),
    .wl_st  (lcl_nxt),
    .wl_tag (l_tag),
    .ws_en  (ev_snp_hit),
    .ws_idx (s_idx),
    .ws_st  (snp_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_state  <= LN_I;
      bus_op     <= BOP_NONE;
      bus_addr   <= '0;
      evict_wb   <= 1'b0;
      evict_addr <= '0;
      snp_hit    <= 1'b0;
      snp_supply <= 1'b0;
    end else begin
      rsp_valid  <= lcl_valid;
      rsp_hit    <= lcl_valid && ev_lcl_hit;
      rsp_state  <= lcl_nxt;
      bus_op     <= lcl_op;
      bus_addr   <= lcl_addr;
      evict_wb   <= ev_evict;
      evict_addr <= victim;
      snp_hit    <= ev_snp_hit;
      snp_supply <= ev_snp_supply;
    end
  end

endmodule

// File: rtl/wo_coh_checker.sv
module wo_coh_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lcl_valid,
  input logic              snp_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [1:0]        rsp_state,
  input logic [1:0]        bus_op,
  input logic [ADDR_W-1:0] lcl_addr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              evict_wb,
  input logic              snp_hit,
  input logic              snp_supply
);

  assert_rsp_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_valid |=> rsp_valid);

  assert_no_spurious_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !lcl_valid |=> !rsp_valid);

  assert_snoop_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |=> !snp_hit && !snp_supply);

  assert_bus_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_valid |=> (bus_addr == $past(lcl_addr)));

  assert_readmiss_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && bus_op == 2'd1) |-> (!rsp_hit && rsp_state == 2'd1));

  assert_hit_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (bus_op != 2'd1));

  assert_wthru_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == 2'd2) |-> (rsp_valid && rsp_state == 2'd2));

  assert_dirty_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_state == 2'd3) |-> (bus_op == 2'd0 && rsp_hit));

  assert_evict_on_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evict_wb |-> (rsp_valid && !rsp_hit && bus_op != 2'd0));

  assert_supply_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> snp_hit);

  assert_idle_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (bus_op == 2'd0 && !evict_wb));

endmodule

bind wo_coh_ctrl wo_coh_checker #(.ADDR_W(ADDR_W)) u_wo_coh_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .lcl_valid  (lcl_valid),
  .snp_valid  (snp_valid),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_state  (rsp_state),
  .bus_op     (bus_op),
  .lcl_addr   (lcl_addr),
  .bus_addr   (bus_addr),
  .evict_wb   (evict_wb),
  .snp_hit    (snp_hit),
  .snp_supply (snp_supply)
);

// File: tb/tb_wo_coh_ctrl.sv
module tb_wo_coh_ctrl;

  localparam int AW  = 10;
  localparam int IW  = 2;
  localparam int TW  = AW - IW;
  localparam int NL  = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lcl_valid = 1'b0, lcl_write = 1'b0;
  logic [AW-1:0] lcl_addr = '0;
  logic          snp_valid = 1'b0, snp_write = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          rsp_valid, rsp_hit, evict_wb, snp_hit, snp_supply;
  logic [1:0]    rsp_state, bus_op;
  logic [AW-1:0] bus_addr, evict_addr;

  always #4 clk = ~clk;

  wo_coh_ctrl #(.ADDR_W(AW), .IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n),
    .lcl_valid(lcl_valid), .lcl_write(lcl_write), .lcl_addr(lcl_addr),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_state(rsp_state),
    .bus_op(bus_op), .bus_addr(bus_addr), .evict_wb(evict_wb),
    .evict_addr(evict_addr), .snp_hit(snp_hit), .snp_supply(snp_supply)
  );

  typedef struct {
    string         req;
    logic          v;
    logic          hit;
    logic [1:0]    st;
    logic [1:0]    op;
    logic [AW-1:0] baddr;
    logic          ev;
    logic [AW-1:0] eaddr;
    logic          shit;
    logic          sup;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done = 1'b0;

  // independent line model: 0 I, 1 V, 2 R, 3 D
  logic [1:0]    m_st  [NL];
  logic [TW-1:0] m_tag [NL];

  function automatic logic [AW-1:0] mk(input int tag, input int idx);
    return AW'((tag << IW) | idx);
  endfunction

  task automatic step(input string req, input logic lv, input logic lw, input logic [AW-1:0] la,
                      input logic sv, input logic sw, input logic [AW-1:0] sa);
    exp_t e;
    int li, si;
    @(negedge clk);
    lcl_valid = lv; lcl_write = lw; lcl_addr = la;
    snp_valid = sv; snp_write = sw; snp_addr = sa;
    e.req = req; e.v = lv; e.hit = 0; e.st = 0; e.op = 0; e.baddr = la;
    e.ev = 0; e.eaddr = 0; e.shit = 0; e.sup = 0;
    si = int'(sa[IW-1:0]);
    li = int'(la[IW-1:0]);
    if (sv && m_st[si] != 2'd0 && m_tag[si] == sa[AW-1:IW]) begin
      e.shit = 1;
      if (sw) m_st[si] = 2'd0;
      else begin
        e.sup = (m_st[si] == 2'd3);
        m_st[si] = 2'd1;
      end
    end
    if (lv) begin
      e.hit = (m_st[li] != 2'd0) && (m_tag[li] == la[AW-1:IW]);
      if (e.hit) begin
        if (lw) begin
          if (m_st[li] == 2'd1) begin e.op = 2; m_st[li] = 2'd2; end
          else m_st[li] = 2'd3;
        end
      end else begin
        if (m_st[li] == 2'd3) begin
          e.ev = 1;
          e.eaddr = {m_tag[li], la[IW-1:0]};
        end
        e.op = lw ? 2'd2 : 2'd1;
        m_st[li] = lw ? 2'd2 : 2'd1;
        m_tag[li] = la[AW-1:IW];
      end
      e.st = m_st[li];
    end
    exp_q.push_back(e);
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a);
    step(req, 1, 0, a, 0, 0, '0);
  endtask
  task automatic wr(input string req, input logic [AW-1:0] a);
    step(req, 1, 1, a, 0, 0, '0);
  endtask
  task automatic snp(input string req, input logic w, input logic [AW-1:0] a);
    step(req, 0, 0, '0, 1, w, a);
  endtask

  task automatic chk(input string req, input string what, input logic [AW-1:0] act,
                     input logic [AW-1:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: outputs of a request are compared two ns after the following edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, "rsp_valid", AW'(rsp_valid), AW'(e.v));
        chk(e.req, "snp_hit", AW'(snp_hit), AW'(e.shit));
        chk(e.req, "snp_supply", AW'(snp_supply), AW'(e.sup));
        chk(e.req, "bus_op", AW'(bus_op), AW'(e.op));
        chk(e.req, "evict_wb", AW'(evict_wb), AW'(e.ev));
        if (e.v) begin
          chk(e.req, "rsp_hit", AW'(rsp_hit), AW'(e.hit));
          chk(e.req, "rsp_state", AW'(rsp_state), AW'(e.st));
          if (e.op != 0) chk(e.req, "bus_addr", bus_addr, e.baddr);
          if (e.ev) chk(e.req, "evict_addr", evict_addr, e.eaddr);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R12 idle cycle right after reset
    step("R12", 0, 0, '0, 0, 0, '0);
    // R1 / R2: every line starts invalid, read misses fill shared
    rd("R1", mk(5, 1));
    rd("R1", mk(0, 0));
    rd("R3", mk(5, 1));          // shared hit
    wr("R4", mk(5, 1));          // V -> R, write-through
    wr("R5", mk(5, 1));          // R -> D quiet
    wr("R5", mk(5, 1));          // D stays D
    snp("R8", 0, mk(5, 1));      // D supplies, -> V
    rd("R8", mk(5, 1));          // probe: V
    wr("R4", mk(5, 1));          // V -> R
    snp("R9", 0, mk(5, 1));      // R -> V, no supply
    snp("R9", 0, mk(5, 1));      // V stays V
    rd("R9", mk(5, 1));          // probe
    snp("R10", 1, mk(6, 1));     // other tag: no effect
    rd("R10", mk(5, 1));         // still hits
    snp("R10", 1, mk(5, 1));     // invalidate
    rd("R10", mk(5, 1));         // misses
    // R6 / R7 replacement
    wr("R6", mk(9, 2));          // write miss -> R
    wr("R5", mk(9, 2));          // -> D
    rd("R7", mk(3, 2));          // replaces dirty: write-back
    wr("R7", mk(4, 2));          // replaces V: no write-back
    rd("R7", mk(7, 2));          // replaces R: no write-back
    // R11 same-index collisions
    wr("R11", mk(2, 3));         // R
    step("R11", 1, 0, mk(2, 3), 1, 1, mk(2, 3)); // snoop write first -> read misses
    wr("R11", mk(2, 3));         // V -> R
    wr("R11", mk(2, 3));         // -> D
    step("R11", 1, 1, mk(2, 3), 1, 0, mk(2, 3)); // supply, then write on V -> R
    step("R11", 1, 0, mk(1, 3), 1, 0, mk(2, 3)); // snoop hit R->V, local miss replaces V
    rd("R11", mk(1, 3));
    // R12 trailing idle
    step("R12", 0, 0, '0, 0, 0, '0);
    step("R12", 0, 0, '0, 1, 0, mk(7, 0)); // snoop miss on a dead tag
    @(negedge clk);
    lcl_valid = 0; snp_valid = 0;
    repeat (4) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule